// File: doc/BRIEF.md
# Host I/O Space Address Router

This block sits between the host processor's I/O cycles and a PCI host bridge and decides, cycle by cycle, which target claims each I/O access. There are four targets. The bridge keeps a small group of its own I/O-mapped registers. It also has an internal configuration register file and can reach PCI configuration space and PCI I/O space. The router owns two of the bridge-local registers. The first holds the configuration window enable. The second holds a forward value that supplies the PCI bus number for translated configuration cycles.

A fixed I/O window, C000h to CFFFh, changes meaning with the enable bit. While the bit is clear the window is ordinary PCI I/O space. While it is set, the lowest 256 addresses of the window are claimed by the bridge's internal configuration registers and the rest map onto PCI configuration space. For those, the address is split into a device number and a register offset, and the bus number comes from the forward register. The six local register locations are parameters and always win over the window decode. Decisions are registered: the routing for a cycle presented with the strobe high appears on the outputs in the following clock cycle.

Top module: `hio_router`

## Requirements
- R1: During and after synchronous reset no target select is asserted, the enable bit is clear and the forward register holds zero, so the first cycles after reset see the window as PCI I/O space and bus 0.
- R2: One clock after a cycle with `io_valid` high, exactly one bit of `sel_o` is set, with encoding bit0 = local register, bit1 = bridge configuration registers, bit2 = PCI configuration space, bit3 = PCI I/O space. One clock after a cycle with `io_valid` low, `sel_o` is zero.
- R3: An address equal to one of the six local register locations selects bit0 and reports its index on `loc_idx_o`: 0 enable, 1 configuration address, 2 turbo-reset control, 3 forward, 4 mechanism control, 5 configuration data. This takes priority over every range decode, including inside the window. For any other target `loc_idx_o` is 7.
- R4: With the enable bit set, addresses C100h to CFFFh (not local) select bit2.
- R5: With the enable bit set, addresses C000h to C0FFh (not local) select bit1 and are not forwarded.
- R6: With the enable bit clear, every address from C000h to CFFFh (not local) selects bit3.
- R7: Addresses outside the window that are not local always select bit3, and `pci_io_addr_o` equals the CPU address unchanged for every accepted cycle.
- R8: For every accepted cycle, `cfg_reg_o` is address bits 7:0, `cfg_dev_o` is address bits 11:8 and `cfg_bus_o` is the forward register value at that cycle.
- R9: A write cycle to the enable location loads bit 0 of `io_wdata` into the enable bit, and a write to the forward location loads all 8 bits. A read leaves both unchanged. The new value governs decodes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | CPU I/O cycle present this clock |
| io_write | input | 1 | 1 = write cycle, 0 = read cycle |
| io_addr | input | 16 | CPU I/O address |
| io_wdata | input | 8 | Write data for the enable and forward registers |
| sel_o | output | 4 | One-hot target select, registered |
| loc_idx_o | output | 3 | Local register index, 7 when not local |
| cfg_bus_o | output | 8 | Translated configuration bus number |
| cfg_dev_o | output | 4 | Translated configuration device number |
| cfg_reg_o | output | 8 | Translated configuration register offset |
| pci_io_addr_o | output | 16 | Pass-through PCI I/O address |

## Verification
The decode is tried with the window first disabled and then enabled. In each state the bench hits the window edges (BFFFh, C000h, C0FFh, C100h, CFFFh, D000h), which separates an off-by-one in either sub-range from a wrong enable polarity. A local location placed inside the window shows whether the register match really outranks the range decode. Back-to-back writes followed at once by a window access, and reads of the enable location, show whether a register update lands one cycle later and whether reads leave it alone. A long pseudo-random address stream then runs with the enable toggled, with idle gaps in between, and checks one-hotness and address translation against the model on every clock.

// File: rtl/hio_router_pkg.sv
package hio_router_pkg;

    typedef enum logic [1:0] {
        TGT_LOCAL  = 2'd0,
        TGT_BRCFG  = 2'd1,
        TGT_PCICFG = 2'd2,
        TGT_PCIIO  = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        LR_ENABLE = 3'd0,
        LR_CADDR  = 3'd1,
        LR_TURBO  = 3'd2,
        LR_FWD    = 3'd3,
        LR_MECH   = 3'd4,
        LR_CDATA  = 3'd5,
        LR_NONE   = 3'd7
    } lreg_e;

    localparam int unsigned LOC_N   = 6;
    localparam int unsigned TGT_N   = 4;
    localparam int unsigned LIDX_W  = 3;

    typedef struct packed {
        tgt_e  tgt;
        lreg_e lreg;
    } route_t;

    function automatic logic [TGT_N-1:0] tgt_onehot(input tgt_e t);
        logic [TGT_N-1:0] v;
        v = '0;
        v[t] = 1'b1;
        return v;
    endfunction

    function automatic lreg_e idx_to_lreg(input int unsigned i);
        lreg_e r;
        case (i)
            0:       r = LR_ENABLE;
            1:       r = LR_CADDR;
            2:       r = LR_TURBO;
            3:       r = LR_FWD;
            4:       r = LR_MECH;
            5:       r = LR_CDATA;
            default: r = LR_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hio_local_match.sv
module hio_local_match
    import hio_router_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [LOC_N-1:0][ADDR_W-1:0] LOC_TABLE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output lreg_e             idx
);

    logic [LOC_N-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < LOC_N; g++) begin : g_cmp
            assign hit_vec[g] = (addr == LOC_TABLE[g]);
        end
    endgenerate

    always_comb begin
        idx = LR_NONE;
        for (int i = LOC_N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                idx = idx_to_lreg(i);
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/hio_range_decode.sv
module hio_range_decode
    import hio_router_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] BRG_LAST = 16'hC0FF,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'hCFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_en,
    input  logic              loc_hit,
    input  lreg_e             loc_idx,
    output route_t            route
);

    logic in_brg;
    logic in_cfg;

    assign in_brg = (addr >= WIN_BASE) && (addr <= BRG_LAST);
    assign in_cfg = (addr >  BRG_LAST) && (addr <= WIN_LAST);

    always_comb begin
        route.lreg = LR_NONE;
        if (loc_hit) begin
            route.tgt  = TGT_LOCAL;
            route.lreg = loc_idx;
        end else if (cfg_en && in_brg) begin
            route.tgt = TGT_BRCFG;
        end else if (cfg_en && in_cfg) begin
            route.tgt = TGT_PCICFG;
        end else begin
            route.tgt = TGT_PCIIO;
        end
    end

endmodule

// File: rtl/hio_ctl_regs.sv
module hio_ctl_regs #(
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic             hit_ena,
    input  logic             hit_fwd,
    input  logic [BUS_W-1:0] wdata,
    output logic             cfg_en,
    output logic [BUS_W-1:0] fwd_bus
);

    logic wr_ena;
    logic wr_fwd;

    assign wr_ena = io_valid && io_write && hit_ena;
    assign wr_fwd = io_valid && io_write && hit_fwd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_en  <= 1'b0;
            fwd_bus <= '0;
        end else begin
            if (wr_ena) cfg_en  <= wdata[0];
            if (wr_fwd) fwd_bus <= wdata;
        end
    end

    // R1: registers come out of reset cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) && !rst |-> (cfg_en == 1'b0) && (fwd_bus == '0));

    // R9: a read cycle never alters either register
    a_r9_read_keeps: assert property (@(posedge clk) disable iff (rst)
        io_valid && !io_write |=> $stable(cfg_en) && $stable(fwd_bus));

    // R9: a write to the forward location lands on the next clock
    a_r9_fwd_load: assert property (@(posedge clk) disable iff (rst)
        io_valid && io_write && hit_fwd |=> fwd_bus == $past(wdata));

endmodule

// File: rtl/hio_cfg_xlate.sv
module hio_cfg_xlate #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned DEV_W   = 4,
    parameter int unsigned OFF_W   = 8,
    parameter int unsigned DEV_LSB = OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  fwd_bus,
    output logic [BUS_W-1:0]  bus,
    output logic [DEV_W-1:0]  dev,
    output logic [OFF_W-1:0]  off
);

    assign bus = fwd_bus;
    assign dev = addr[DEV_LSB + DEV_W - 1 : DEV_LSB];
    assign off = addr[OFF_W-1:0];

endmodule

// File: rtl/hio_router.sv
module hio_router
    import hio_router_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned DEV_W  = 4,
    parameter int unsigned OFF_W  = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] BRG_LAST = 16'hC0FF,
    parameter logic [ADDR_W-1:0] WIN_LAST = 16'hCFFF,
    parameter logic [ADDR_W-1:0] LOC_ENA   = 16'h0CF8,
    parameter logic [ADDR_W-1:0] LOC_CADDR = 16'h0CF0,
    parameter logic [ADDR_W-1:0] LOC_TURBO = 16'h0CF9,
    parameter logic [ADDR_W-1:0] LOC_FWD   = 16'h0CFA,
    parameter logic [ADDR_W-1:0] LOC_MECH  = 16'h0CFB,
    parameter logic [ADDR_W-1:0] LOC_CDATA = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BUS_W-1:0]  io_wdata,
    output logic [TGT_N-1:0]  sel_o,
    output logic [LIDX_W-1:0] loc_idx_o,
    output logic [BUS_W-1:0]  cfg_bus_o,
    output logic [DEV_W-1:0]  cfg_dev_o,
    output logic [OFF_W-1:0]  cfg_reg_o,
    output logic [ADDR_W-1:0] pci_io_addr_o
);

    localparam logic [LOC_N-1:0][ADDR_W-1:0] LOC_TABLE =
        {LOC_CDATA, LOC_MECH, LOC_FWD, LOC_TURBO, LOC_CADDR, LOC_ENA};

    logic             loc_hit;
    lreg_e            loc_idx;
    logic             cfg_en;
    logic [BUS_W-1:0] fwd_bus;
    route_t           route;
    logic [BUS_W-1:0] x_bus;
    logic [DEV_W-1:0] x_dev;
    logic [OFF_W-1:0] x_off;

    hio_local_match #(
        .ADDR_W    (ADDR_W),
        .LOC_TABLE (LOC_TABLE)
    ) u_match (
        .addr (io_addr),
        .hit  (loc_hit),
        .idx  (loc_idx)
    );

    hio_ctl_regs #(
        .BUS_W (BUS_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_valid (io_valid),
        .io_write (io_write),
        .hit_ena  (loc_hit && (loc_idx == LR_ENABLE)),
        .hit_fwd  (loc_hit && (loc_idx == LR_FWD)),
        .wdata    (io_wdata),
        .cfg_en   (cfg_en),
        .fwd_bus  (fwd_bus)
    );

    hio_range_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .BRG_LAST (BRG_LAST),
        .WIN_LAST (WIN_LAST)
    ) u_dec (
        .addr    (io_addr),
        .cfg_en  (cfg_en),
        .loc_hit (loc_hit),
        .loc_idx (loc_idx),
        .route   (route)
    );

    hio_cfg_xlate #(
        .ADDR_W  (ADDR_W),
        .BUS_W   (BUS_W),
        .DEV_W   (DEV_W),
        .OFF_W   (OFF_W),
        .DEV_LSB (OFF_W)
    ) u_xlate (
        .addr    (io_addr),
        .fwd_bus (fwd_bus),
        .bus     (x_bus),
        .dev     (x_dev),
        .off     (x_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_o         <= '0;
            loc_idx_o     <= LR_NONE;
            cfg_bus_o     <= '0;
            cfg_dev_o     <= '0;
            cfg_reg_o     <= '0;
            pci_io_addr_o <= '0;
        end else begin
            sel_o <= io_valid ? tgt_onehot(route.tgt) : '0;
            if (io_valid) begin
                loc_idx_o     <= route.lreg;
                cfg_bus_o     <= x_bus;
                cfg_dev_o     <= x_dev;
                cfg_reg_o     <= x_off;
                pci_io_addr_o <= io_addr;
            end
        end
    end

    // R2: exactly one target after an accepted cycle, none after an idle one
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $past(io_valid) && !$past(rst) |-> $countones(sel_o) == 1);
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(io_valid) |-> sel_o == '0);

    // R3: enable location is claimed locally whatever the window state
    a_r3_local_ena: assert property (@(posedge clk) disable iff (rst)
        $past(io_valid) && !$past(rst) && ($past(io_addr) == LOC_ENA)
        |-> sel_o[0] && (loc_idx_o == LR_ENABLE));

    // R4: enabled window above the bridge range goes to PCI configuration
    a_r4_cfg_route: assert property (@(posedge clk) disable iff (rst)
        $past(io_valid && cfg_en && !loc_hit && (io_addr > BRG_LAST) && (io_addr <= WIN_LAST))
        && !$past(rst) |-> sel_o[2]);

    // R6: disabled window is plain PCI I/O
    a_r6_io_route: assert property (@(posedge clk) disable iff (rst)
        $past(io_valid && !cfg_en && !loc_hit && (io_addr >= WIN_BASE) && (io_addr <= WIN_LAST))
        && !$past(rst) |-> sel_o[3]);

    // R7: the pass-through address is the CPU address unchanged
    a_r7_passthru: assert property (@(posedge clk) disable iff (rst)
        $past(io_valid) && !$past(rst) |-> pci_io_addr_o == $past(io_addr));

endmodule

// File: tb/hio_router_bench.sv
module hio_router_bench;

    localparam logic [15:0] L_ENA   = 16'h0CF8;
    localparam logic [15:0] L_CADDR = 16'h0CF0;
    localparam logic [15:0] L_TURBO = 16'h0CF9;
    localparam logic [15:0] L_FWD   = 16'h0CFA;
    localparam logic [15:0] L_MECH  = 16'hC204;
    localparam logic [15:0] L_CDATA = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr  = '0;
    logic [7:0]  io_wdata = '0;
    logic [3:0]  sel_o;
    logic [2:0]  loc_idx_o;
    logic [7:0]  cfg_bus_o;
    logic [3:0]  cfg_dev_o;
    logic [7:0]  cfg_reg_o;
    logic [15:0] pci_io_addr_o;

    always #2 clk = ~clk;

    hio_router #(
        .LOC_ENA (L_ENA), .LOC_CADDR (L_CADDR), .LOC_TURBO (L_TURBO),
        .LOC_FWD (L_FWD), .LOC_MECH  (L_MECH),  .LOC_CDATA (L_CDATA)
    ) u_hio_router (
        .clk (clk), .rst (rst), .io_valid (io_valid), .io_write (io_write),
        .io_addr (io_addr), .io_wdata (io_wdata), .sel_o (sel_o),
        .loc_idx_o (loc_idx_o), .cfg_bus_o (cfg_bus_o), .cfg_dev_o (cfg_dev_o),
        .cfg_reg_o (cfg_reg_o), .pci_io_addr_o (pci_io_addr_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int          m_en  = 0;
    int          m_fwd = 0;
    int          have_exp = 0;
    int          e_valid = 0;
    int          e_tgt = 0;
    int          e_idx = 7;
    int          e_addr = 0;
    int          e_bus = 0;
    string       e_req = "R2";

    function automatic int local_index(int a);
        int lst[6];
        lst = '{int'(L_ENA), int'(L_CADDR), int'(L_TURBO), int'(L_FWD), int'(L_MECH), int'(L_CDATA)};
        foreach (lst[i]) if (lst[i] == a) return i;
        return 7;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit w, input int a, input int d);
        @(negedge clk);
        if (have_exp) begin
            if (e_valid) begin
                check({e_req, " select"}, int'(sel_o), 1 << e_tgt);
                check("R3 local index", int'(loc_idx_o), e_idx);
                check("R7 io address", int'(pci_io_addr_o), e_addr);
                check("R8 bus", int'(cfg_bus_o), e_bus);
                check("R8 device", int'(cfg_dev_o), (e_addr >> 8) & 15);
                check("R8 offset", int'(cfg_reg_o), e_addr & 255);
            end else begin
                check("R2 idle select", int'(sel_o), 0);
            end
        end
        // expectation for the cycle being driven now
        have_exp = 1;
        e_valid  = v;
        if (v) begin
            e_addr = a;
            e_bus  = m_fwd;
            e_idx  = local_index(a);
            if (e_idx != 7) begin e_tgt = 0; e_req = "R3"; end
            else if (a >= 'hC000 && a <= 'hCFFF && m_en != 0) begin
                if (a <= 'hC0FF) begin e_tgt = 1; e_req = "R5"; end
                else begin e_tgt = 2; e_req = "R4"; end
            end else if (a >= 'hC000 && a <= 'hCFFF) begin e_tgt = 3; e_req = "R6"; end
            else begin e_tgt = 3; e_req = "R7"; end
            if (w && e_idx == 0) m_en  = d & 1;
            if (w && e_idx == 3) m_fwd = d & 255;
        end
        io_valid = v;
        io_write = w;
        io_addr  = a[15:0];
        io_wdata = d[7:0];
    endtask

    task automatic rd(int a);           step(1'b1, 1'b0, a, 0); endtask
    task automatic wr(int a, int d);    step(1'b1, 1'b1, a, d); endtask
    task automatic idle();              step(1'b0, 1'b0, 0, 0); endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int lfsr;
        repeat (3) @(negedge clk);
        check("R1 reset select", int'(sel_o), 0);
        check("R1 reset index", int'(loc_idx_o), 7);
        @(negedge clk);
        rst = 1'b0;
        idle();
        // R1/R6: window off after reset, bus 0
        rd('hC100); rd('hC000); rd('hCFFF); rd('hC3A7);
        // R7: outside the window
        rd('hBFFF); rd('hD000); rd('h1234); idle();
        // R3: every local location, including one inside the window
        rd(L_ENA); rd(L_CADDR); rd(L_TURBO); rd(L_FWD); rd(L_MECH); rd(L_CDATA);
        // R9: load forward and enable; window access directly after
        wr(L_FWD, 'h5A); wr(L_ENA, 'h01); rd('hC100);
        rd('hC000); rd('hC0FF); rd('hCFFF); rd('hC3A7); rd('hBFFF); rd('hD000);
        rd(L_MECH); idle(); rd('hC204);
        // R9: reads of the registers leave them alone
        rd(L_ENA); rd(L_FWD); rd('hC5E1);
        // R5/R4 boundary sweep
        for (int a = 'hC0F0; a <= 'hC110; a++) rd(a);
        // R9: enable write uses bit 0 only
        wr(L_ENA, 'hFE); rd('hC100); rd('hC050);
        wr(L_FWD, 'hC3); wr(L_ENA, 'h81); rd('hCA12);
        // pseudo-random traffic with enable toggling
        lfsr = 'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
            if ((i % 97) == 0) wr(L_ENA, i & 1);
            else if ((i % 131) == 0) wr(L_FWD, lfsr & 255);
            else if ((lfsr & 7) == 0) idle();
            else if ((lfsr & 1) != 0) rd('hC000 | (lfsr & 'h0FFF));
            else rd(lfsr);
        end
        idle(); idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule